// File: doc/BRIEF.md
# Device Lifecycle State Controller

This block keeps the security lifecycle of a device and turns it into boot policy. A device starts either open or locked, depending on a close fuse bit. When locked, a correct unlock password presented through the debug port moves it into an analysis state. That transition is allowed once per device, and a one-time-use flag records it. A second password returns the device from analysis to locked. Fuse programming is modelled as sticky register state that is reloaded from the fuse inputs on reset.

The block also decides how the device boots. Authentication is mandatory only when the device is locked. A failed authentication blocks the next-stage image only in that state. The analysis state disables every boot feature and leaves only the relock path working. Engineering boot is granted only to an open device whose boot pins carry the engineering code.

Top module: `lc_lifecycle_ctrl`

## Requirements
- R1: On synchronous reset, `state_o` loads 2'b01 (locked) when `fuse_close_i` is 1 and 2'b00 (open) otherwise. The one-time-use flag loads from `fuse_used_i`, and `pw_err_o` is 0. The encoding of analysis is 2'b10.
- R2: `auth_req_o` is 1 exactly when the state is locked.
- R3: `boot_ok_o` is 1 in open regardless of `auth_pass_i`, equals `auth_pass_i` in locked, and is 0 in analysis.
- R4: `eng_ok_o` is 1 only when the state is open and `boot_pins_i` equals 3'b100.
- R5: In locked, with the flag clear, an `unlock_req_i` cycle whose `dbg_pw_i` equals `fuse_pw_i[14:0]` moves the state to analysis at the next clock and sets the one-time-use flag.
- R6: In locked, with the one-time-use flag set, an unlock request is ignored even with the correct password. The state stays locked and no error is raised.
- R7: In analysis, a `relock_req_i` cycle whose `dbg_pw_i` equals `fuse_pw_i[29:15]` moves the state to locked at the next clock.
- R8: A request that is acted on but carries a wrong password leaves the state unchanged and raises `pw_err_o` for exactly the following cycle.
- R9: The following requests are ignored, with no state change and no error: unlock in analysis, relock in locked, and any request in open.
- R10: Once the state leaves open, only reset can return it to open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fuse_close_i | input | 1 | Close fuse bit |
| fuse_used_i | input | 1 | Fuse copy of the one-time analysis-entry flag |
| fuse_pw_i | input | 30 | Stored passwords: relock [29:15], unlock [14:0] |
| dbg_pw_i | input | 15 | Password written through the debug port |
| unlock_req_i | input | 1 | Unlock request strobe |
| relock_req_i | input | 1 | Relock request strobe |
| auth_pass_i | input | 1 | Authentication result, 1 = pass |
| boot_pins_i | input | 3 | Boot pin code |
| state_o | output | 2 | Lifecycle state |
| auth_req_o | output | 1 | Authentication is mandatory |
| boot_ok_o | output | 1 | Next-stage image may be launched |
| eng_ok_o | output | 1 | Engineering boot is granted |
| pw_err_o | output | 1 | One-cycle password mismatch pulse |

## Verification
The hardest case to reach is the refused second unlock. The device must already have used its one analysis entry and then been relocked, so the stimulus runs the full sequence of unlock, relock and then a correct unlock again. A separate reset with the use flag already set in the fuse reaches the same refusal without that history. The mismatch pulse is sampled in the cycle right after each wrong request and again one cycle later, which shows that it lasts only one cycle.

// File: rtl/lc_pkg.sv
package lc_pkg;

    typedef enum logic [1:0] {
        LC_OPEN     = 2'b00,
        LC_LOCKED   = 2'b01,
        LC_ANALYSIS = 2'b10
    } lc_state_e;

    typedef struct packed {
        lc_state_e state;
        logic      used;
        logic      pw_err;
    } lc_regs_t;

endpackage

// File: rtl/lc_pw_cmp.sv
module lc_pw_cmp #(
    parameter int PW_W = 15
) (
    input  logic [PW_W-1:0] stored_i,
    input  logic [PW_W-1:0] cand_i,
    output logic            match_o
);
    // Full-width equality check of a candidate password against one stored field.
    assign match_o = (stored_i == cand_i);
endmodule

// File: rtl/lc_policy.sv
module lc_policy
    import lc_pkg::*;
#(
    parameter int               PIN_W    = 3,
    parameter logic [PIN_W-1:0] ENG_CODE = 3'b100
) (
    input  lc_state_e        state_i,
    input  logic             auth_pass_i,
    input  logic [PIN_W-1:0] boot_pins_i,
    output logic             auth_req_o,
    output logic             boot_ok_o,
    output logic             eng_ok_o
);
    always_comb begin
        auth_req_o = 1'b0;
        boot_ok_o  = 1'b0;
        eng_ok_o   = 1'b0;
        case (state_i)
            LC_OPEN: begin
                boot_ok_o = 1'b1;
                eng_ok_o  = (boot_pins_i == ENG_CODE);
            end
            LC_LOCKED: begin
                auth_req_o = 1'b1;
                boot_ok_o  = auth_pass_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lc_lifecycle_ctrl.sv
module lc_lifecycle_ctrl
    import lc_pkg::*;
#(
    parameter int               PW_W     = 15,
    parameter int               PIN_W    = 3,
    parameter logic [PIN_W-1:0] ENG_CODE = 3'b100
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               fuse_close_i,
    input  logic               fuse_used_i,
    input  logic [2*PW_W-1:0]  fuse_pw_i,
    input  logic [PW_W-1:0]    dbg_pw_i,
    input  logic               unlock_req_i,
    input  logic               relock_req_i,
    input  logic               auth_pass_i,
    input  logic [PIN_W-1:0]   boot_pins_i,
    output logic [1:0]         state_o,
    output logic               auth_req_o,
    output logic               boot_ok_o,
    output logic               eng_ok_o,
    output logic               pw_err_o
);
    localparam int N_FIELDS  = 2;
    localparam int F_UNLOCK  = 0;
    localparam int F_RELOCK  = 1;

    lc_regs_t            regs_d, regs_q;
    logic [N_FIELDS-1:0] match;

    // One comparator per stored password field; field k sits at [k*PW_W +: PW_W].
    for (genvar k = 0; k < N_FIELDS; k++) begin : g_cmp
        lc_pw_cmp #(.PW_W(PW_W)) i_cmp (
            .stored_i (fuse_pw_i[k*PW_W +: PW_W]),
            .cand_i   (dbg_pw_i),
            .match_o  (match[k])
        );
    end

    always_comb begin
        regs_d        = regs_q;
        regs_d.pw_err = 1'b0;
        case (regs_q.state)
            LC_LOCKED: begin
                if (unlock_req_i && !regs_q.used) begin
                    if (match[F_UNLOCK]) begin
                        regs_d.state = LC_ANALYSIS;
                        regs_d.used  = 1'b1;
                    end else begin
                        regs_d.pw_err = 1'b1;
                    end
                end
            end
            LC_ANALYSIS: begin
                if (relock_req_i) begin
                    if (match[F_RELOCK]) regs_d.state  = LC_LOCKED;
                    else                 regs_d.pw_err = 1'b1;
                end
            end
            default: ;
        endcase
        if (rst_i) begin
            regs_d.state  = fuse_close_i ? LC_LOCKED : LC_OPEN;
            regs_d.used   = fuse_used_i;
            regs_d.pw_err = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    lc_policy #(.PIN_W(PIN_W), .ENG_CODE(ENG_CODE)) i_policy (
        .state_i     (regs_q.state),
        .auth_pass_i (auth_pass_i),
        .boot_pins_i (boot_pins_i),
        .auth_req_o  (auth_req_o),
        .boot_ok_o   (boot_ok_o),
        .eng_ok_o    (eng_ok_o)
    );

    assign state_o  = regs_q.state;
    assign pw_err_o = regs_q.pw_err;

    // Assertions

    assert_err_keeps_state_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        pw_err_o |-> (state_o == $past(state_o)));

    assert_used_sticky_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        regs_q.used |=> regs_q.used);

    assert_analysis_from_locked_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == LC_ANALYSIS && $past(state_o) != LC_ANALYSIS)
            |-> ($past(state_o) == LC_LOCKED && !$past(regs_q.used)));

    assert_no_return_open_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o != LC_OPEN) |=> (state_o != LC_OPEN));

    assert_analysis_gated_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == LC_ANALYSIS) |-> (!boot_ok_o && !eng_ok_o));

    assert_locked_auth_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == LC_LOCKED && !auth_pass_i) |-> (auth_req_o && !boot_ok_o));

    assert_eng_only_open_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        eng_ok_o |-> (state_o == LC_OPEN && boot_pins_i == ENG_CODE));

endmodule

// File: tb/test_lc_lifecycle_ctrl.sv
module test_lc_lifecycle_ctrl;
    localparam int PW_W = 15;
    localparam logic [PW_W-1:0] PW_UNL = 15'h1A2B;
    localparam logic [PW_W-1:0] PW_REL = 15'h5C3D;
    localparam logic [1:0] S_OPEN = 2'b00, S_LOCK = 2'b01, S_ANA = 2'b10;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic fuse_close_i = 1'b0, fuse_used_i = 1'b0;
    logic [2*PW_W-1:0] fuse_pw_i = {PW_REL, PW_UNL};
    logic [PW_W-1:0] dbg_pw_i = '0;
    logic unlock_req_i = 1'b0, relock_req_i = 1'b0, auth_pass_i = 1'b0;
    logic [2:0] boot_pins_i = 3'b000;
    logic [1:0] state_o;
    logic auth_req_o, boot_ok_o, eng_ok_o, pw_err_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lc_lifecycle_ctrl i_lc_lifecycle_ctrl (
        .clk_i(clk), .rst_i(rst_i), .fuse_close_i(fuse_close_i), .fuse_used_i(fuse_used_i),
        .fuse_pw_i(fuse_pw_i), .dbg_pw_i(dbg_pw_i), .unlock_req_i(unlock_req_i),
        .relock_req_i(relock_req_i), .auth_pass_i(auth_pass_i), .boot_pins_i(boot_pins_i),
        .state_o(state_o), .auth_req_o(auth_req_o), .boot_ok_o(boot_ok_o),
        .eng_ok_o(eng_ok_o), .pw_err_o(pw_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic close, input logic used);
        @(negedge clk);
        rst_i = 1'b1; fuse_close_i = close; fuse_used_i = used;
        repeat (2) @(negedge clk);
        rst_i = 1'b0;
    endtask

    // Presents one request cycle; returns at the next falling edge (state/err updated).
    task automatic do_req(input logic unl, input logic rel, input logic [PW_W-1:0] pw);
        dbg_pw_i = pw; unlock_req_i = unl; relock_req_i = rel;
        @(negedge clk);
        unlock_req_i = 1'b0; relock_req_i = 1'b0;
    endtask

    task automatic t_reset_open;
        do_reset(1'b0, 1'b0);
        chk("R1 open reset state", state_o, S_OPEN);
        chk("R1 reset err", pw_err_o, 0);
        chk("R2 open auth_req", auth_req_o, 0);
    endtask

    task automatic t_open_policy;
        auth_pass_i = 1'b0; boot_pins_i = 3'b100; #1;
        chk("R3 open boot with fail", boot_ok_o, 1);
        chk("R4 open eng pins 100", eng_ok_o, 1);
        boot_pins_i = 3'b101; #1;
        chk("R4 open eng pins 101", eng_ok_o, 0);
        boot_pins_i = 3'b000;
        do_req(1'b1, 1'b0, PW_UNL);
        chk("R9 open unlock ignored state", state_o, S_OPEN);
        chk("R9 open unlock no err", pw_err_o, 0);
        do_req(1'b0, 1'b1, 15'h0000);
        chk("R9 open relock ignored err", pw_err_o, 0);
    endtask

    task automatic t_locked_policy;
        do_reset(1'b1, 1'b0);
        chk("R1 locked reset state", state_o, S_LOCK);
        chk("R2 locked auth_req", auth_req_o, 1);
        auth_pass_i = 1'b0; boot_pins_i = 3'b100; #1;
        chk("R3 locked boot fail", boot_ok_o, 0);
        chk("R4 locked eng refused", eng_ok_o, 0);
        auth_pass_i = 1'b1; #1;
        chk("R3 locked boot pass", boot_ok_o, 1);
        boot_pins_i = 3'b000;
        do_req(1'b0, 1'b1, PW_REL);
        chk("R9 relock in locked state", state_o, S_LOCK);
        chk("R9 relock in locked err", pw_err_o, 0);
    endtask

    task automatic t_unlock_mismatch;
        do_req(1'b1, 1'b0, PW_UNL ^ 15'h0001);
        chk("R8 unlock mismatch state", state_o, S_LOCK);
        chk("R8 unlock mismatch err", pw_err_o, 1);
        @(negedge clk);
        chk("R8 err one cycle", pw_err_o, 0);
        do_req(1'b1, 1'b0, PW_REL);
        chk("R8 unlock with relock field", state_o, S_LOCK);
        chk("R8 unlock with relock field err", pw_err_o, 1);
        @(negedge clk);
    endtask

    task automatic t_unlock_ok;
        do_req(1'b1, 1'b0, PW_UNL);
        chk("R5 unlock enters analysis", state_o, S_ANA);
        chk("R5 unlock no err", pw_err_o, 0);
        auth_pass_i = 1'b1; boot_pins_i = 3'b100; #1;
        chk("R3 analysis boot blocked", boot_ok_o, 0);
        chk("R4 analysis eng blocked", eng_ok_o, 0);
        chk("R2 analysis auth_req", auth_req_o, 0);
        boot_pins_i = 3'b000;
        do_req(1'b1, 1'b0, PW_UNL);
        chk("R9 unlock in analysis state", state_o, S_ANA);
        chk("R9 unlock in analysis err", pw_err_o, 0);
    endtask

    task automatic t_relock;
        do_req(1'b0, 1'b1, PW_UNL);
        chk("R8 relock mismatch state", state_o, S_ANA);
        chk("R8 relock mismatch err", pw_err_o, 1);
        @(negedge clk);
        chk("R8 relock err one cycle", pw_err_o, 0);
        do_req(1'b0, 1'b1, PW_REL);
        chk("R7 relock to locked", state_o, S_LOCK);
        chk("R10 relock not open", state_o != S_OPEN, 1);
    endtask

    task automatic t_second_unlock;
        do_req(1'b1, 1'b0, PW_UNL);
        chk("R6 second unlock state", state_o, S_LOCK);
        chk("R6 second unlock no err", pw_err_o, 0);
        do_req(1'b1, 1'b0, 15'h7FFF);
        chk("R6 used wrong pw no err", pw_err_o, 0);
    endtask

    task automatic t_fuse_used;
        do_reset(1'b1, 1'b1);
        chk("R1 used fuse reset state", state_o, S_LOCK);
        do_req(1'b1, 1'b0, PW_UNL);
        chk("R6 fuse-used unlock refused", state_o, S_LOCK);
        chk("R6 fuse-used no err", pw_err_o, 0);
        do_reset(1'b0, 1'b0);
        chk("R10 reset returns open", state_o, S_OPEN);
    endtask

    initial begin
        t_reset_open;
        t_open_policy;
        t_locked_policy;
        t_unlock_mismatch;
        t_unlock_ok;
        t_relock;
        t_second_unlock;
        t_fuse_used;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule